// File: doc/BRIEF.md
# Viewport Scissor Rectangle Composer

This block builds the final scissor rectangle that a rasterizer applies to one viewport, then answers pixel-inside queries against it. A viewport-derived rectangle arrives as four signed integers. It is clamped to the legal screen range of the selected generation. A window-space bypass can replace it with the full screen. When enabled, it is then intersected with a user scissor rectangle. On a load strobe the result is stored and packed into a top-left word and a bottom-right word.

The packing depends on the generation mode. In the newest mode the bottom-right bound is inclusive, and empty rectangles take a dedicated encoding. In the oldest mode empty rectangles take a different encoding. A registered pixel test port reports whether an (x, y) position lies inside the stored rectangle, using exclusive maximum bounds in every mode.

Top module: `vp_scissor_composer`

## Requirements
- R1: Each viewport coordinate is clamped to [0, LIMIT]. LIMIT is 32768 when mode_i is 2 and 16384 for mode_i 0, 1 or 3. Negative values become 0.
- R2: While wspace_i is 1, the viewport rectangle inputs are ignored and the bound becomes (0,0) to (LIMIT,LIMIT).
- R3: With sc_en_i set, the result is the intersection: the larger of the two minimums and the smaller of the two maximums on each axis. With sc_en_i clear, the user scissor inputs have no effect.
- R4: Each word is laid out as {flag[32], y[31:16], x[15:0]}. In modes 0, 1 and 3, tl_o carries flag=1 with (minx,miny), and br_o carries flag=0 with (maxx,maxy). Mode 3 behaves exactly as mode 1.
- R5: In mode 2, tl_o carries flag=0 with (minx,miny), and br_o carries (maxx-1, maxy-1).
- R6: In mode 2, a result with maxx==0 or maxy==0 is encoded as tl_o=(1,1) with flag 0 and br_o=(0,0).
- R7: In mode 0, a result with maxx==0 or maxy==0 is encoded as tl_o=(1,1) with flag 1 and br_o=(1,1). Mode 1 packs an empty result plainly, as in R4.
- R8: The words take the new rectangle one clock after the cycle in which load_i is high. Without load_i they hold their value whatever the other inputs do.
- R9: inside_o is registered. It is high one clock after a query exactly when minx ≤ px_x_i < maxx and miny ≤ px_y_i < maxy, tested against the stored rectangle.
- R10: After reset, tl_o and br_o are zero, inside_o is 0, and the stored rectangle is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Latch a new rectangle |
| mode_i | input | 2 | Generation mode: 0 oldest, 1 legacy, 2 new, 3 as legacy |
| wspace_i | input | 1 | Window-space bypass of the viewport bound |
| vp_minx_i | input | 18 | Signed viewport left edge |
| vp_miny_i | input | 18 | Signed viewport top edge |
| vp_maxx_i | input | 18 | Signed viewport right edge |
| vp_maxy_i | input | 18 | Signed viewport bottom edge |
| sc_en_i | input | 1 | User scissor enable |
| sc_minx_i | input | 16 | User scissor left edge |
| sc_miny_i | input | 16 | User scissor top edge |
| sc_maxx_i | input | 16 | User scissor right edge |
| sc_maxy_i | input | 16 | User scissor bottom edge |
| px_x_i | input | 16 | Pixel query x |
| px_y_i | input | 16 | Pixel query y |
| tl_o | output | 33 | Packed top-left word |
| br_o | output | 33 | Packed bottom-right word |
| inside_o | output | 1 | Registered pixel-inside result |

## Verification
The assertions check several properties on every cycle. The stored maximums never exceed the mode's limit. The words hold steady between loads. The legacy-mode flag is set after every legacy load. Mode 2 keeps the inclusive off-by-one and the empty encoding. No pixel is ever reported inside an empty rectangle. Only the bench scenarios can show the exact clamp results, the bypass replacing the viewport, the intersection arithmetic, the oldest-mode empty encoding and the pixel boundaries at each edge, because those need expected values worked out from chosen stimulus.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  typedef enum logic [1:0] {
    MODE_OLDEST = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_NEW    = 2'd2,
    MODE_ALT    = 2'd3
  } vsc_mode_e;

  localparam int IDX_MINX = 0;
  localparam int IDX_MINY = 1;
  localparam int IDX_MAXX = 2;
  localparam int IDX_MAXY = 3;
  localparam int NUM_EDGES = 4;

  function automatic logic is_new_mode(input logic [1:0] m);
    return m == MODE_NEW;
  endfunction

endpackage

// File: rtl/vsc_bound.sv
module vsc_bound
  import vsc_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int VP_W    = COORD_W + 2,
  parameter int LIM_OLD = 16384,
  parameter int LIM_NEW = 32768
) (
  input  logic [1:0]                          mode_i,
  input  logic                                wspace_i,
  input  logic [NUM_EDGES-1:0][VP_W-1:0]      vp_i,
  output logic [NUM_EDGES-1:0][COORD_W-1:0]   bnd_o,
  output logic [COORD_W-1:0]                  limit_o
);

  localparam logic [COORD_W-1:0] LIM_OLD_C = COORD_W'(LIM_OLD);
  localparam logic [COORD_W-1:0] LIM_NEW_C = COORD_W'(LIM_NEW);
  localparam int PAD_W = VP_W - COORD_W;

  // Saturate a signed coordinate into [0, lim]
  function automatic logic [COORD_W-1:0] clamp_coord(
    input logic signed [VP_W-1:0] v,
    input logic [COORD_W-1:0]     lim
  );
    logic signed [VP_W-1:0] lim_s;
    lim_s = $signed({{PAD_W{1'b0}}, lim});
    if (v < 0)
      return '0;
    else if (v > lim_s)
      return lim;
    else
      return v[COORD_W-1:0];
  endfunction

  assign limit_o = is_new_mode(mode_i) ? LIM_NEW_C : LIM_OLD_C;

  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
    logic [COORD_W-1:0] clamped;
    logic [COORD_W-1:0] bypass_val;
    assign clamped    = clamp_coord($signed(vp_i[e]), limit_o);
    assign bypass_val = (e >= IDX_MAXX) ? limit_o : '0;
    assign bnd_o[e]   = wspace_i ? bypass_val : clamped;
  end

endmodule

// File: rtl/vsc_intersect.sv
module vsc_intersect
  import vsc_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic                              sc_en_i,
  input  logic [NUM_EDGES-1:0][COORD_W-1:0] bnd_i,
  input  logic [NUM_EDGES-1:0][COORD_W-1:0] sc_i,
  output logic [NUM_EDGES-1:0][COORD_W-1:0] fin_o
);

  function automatic logic [COORD_W-1:0] pick_max(
    input logic [COORD_W-1:0] a,
    input logic [COORD_W-1:0] b
  );
    return (a > b) ? a : b;
  endfunction

  function automatic logic [COORD_W-1:0] pick_min(
    input logic [COORD_W-1:0] a,
    input logic [COORD_W-1:0] b
  );
    return (a < b) ? a : b;
  endfunction

  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
    logic [COORD_W-1:0] merged;
    if (e < IDX_MAXX) begin : g_lo
      assign merged = pick_max(bnd_i[e], sc_i[e]);
    end else begin : g_hi
      assign merged = pick_min(bnd_i[e], sc_i[e]);
    end
    assign fin_o[e] = sc_en_i ? merged : bnd_i[e];
  end

endmodule

// File: rtl/vsc_encode.sv
module vsc_encode
  import vsc_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int WORD_W  = 2 * COORD_W + 1
) (
  input  logic [1:0]                        mode_i,
  input  logic [NUM_EDGES-1:0][COORD_W-1:0] fin_i,
  output logic                              empty_o,
  output logic [WORD_W-1:0]                 tl_o,
  output logic [WORD_W-1:0]                 br_o
);

  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  function automatic logic [WORD_W-1:0] pack_word(
    input logic               flag,
    input logic [COORD_W-1:0] y,
    input logic [COORD_W-1:0] x
  );
    return {flag, y, x};
  endfunction

  logic [COORD_W-1:0] minx, miny, maxx, maxy;
  assign minx = fin_i[IDX_MINX];
  assign miny = fin_i[IDX_MINY];
  assign maxx = fin_i[IDX_MAXX];
  assign maxy = fin_i[IDX_MAXY];

  assign empty_o = (maxx == '0) || (maxy == '0);

  always_comb begin
    tl_o = pack_word(1'b1, miny, minx);
    br_o = pack_word(1'b0, maxy, maxx);
    unique case (mode_i)
      MODE_NEW: begin
        if (empty_o) begin
          tl_o = pack_word(1'b0, ONE, ONE);
          br_o = pack_word(1'b0, '0, '0);
        end else begin
          tl_o = pack_word(1'b0, miny, minx);
          br_o = pack_word(1'b0, maxy - ONE, maxx - ONE);
        end
      end
      MODE_OLDEST: begin
        if (empty_o) begin
          tl_o = pack_word(1'b1, ONE, ONE);
          br_o = pack_word(1'b0, ONE, ONE);
        end
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/vsc_pixel_test.sv
module vsc_pixel_test
  import vsc_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_EDGES-1:0][COORD_W-1:0] rect_i,
  input  logic [COORD_W-1:0]                px_x_i,
  input  logic [COORD_W-1:0]                px_y_i,
  output logic                              inside_o
);

  function automatic logic in_span(
    input logic [COORD_W-1:0] v,
    input logic [COORD_W-1:0] lo,
    input logic [COORD_W-1:0] hi
  );
    return (v >= lo) && (v < hi);
  endfunction

  logic hit_x, hit_y;
  assign hit_x = in_span(px_x_i, rect_i[IDX_MINX], rect_i[IDX_MAXX]);
  assign hit_y = in_span(px_y_i, rect_i[IDX_MINY], rect_i[IDX_MAXY]);

  always_ff @(posedge clk) begin
    if (!rst_n) inside_o <= 1'b0;
    else        inside_o <= hit_x && hit_y;
  end

endmodule

// File: rtl/vp_scissor_composer.sv
module vp_scissor_composer
  import vsc_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int LIM_OLD = 16384,
  parameter int LIM_NEW = 32768,
  localparam int VP_W   = COORD_W + 2,
  localparam int WORD_W = 2 * COORD_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [1:0]                mode_i,
  input  logic                      wspace_i,
  input  logic signed [VP_W-1:0]    vp_minx_i,
  input  logic signed [VP_W-1:0]    vp_miny_i,
  input  logic signed [VP_W-1:0]    vp_maxx_i,
  input  logic signed [VP_W-1:0]    vp_maxy_i,
  input  logic                      sc_en_i,
  input  logic [COORD_W-1:0]        sc_minx_i,
  input  logic [COORD_W-1:0]        sc_miny_i,
  input  logic [COORD_W-1:0]        sc_maxx_i,
  input  logic [COORD_W-1:0]        sc_maxy_i,
  input  logic [COORD_W-1:0]        px_x_i,
  input  logic [COORD_W-1:0]        px_y_i,
  output logic [WORD_W-1:0]         tl_o,
  output logic [WORD_W-1:0]         br_o,
  output logic                      inside_o
);

  logic [NUM_EDGES-1:0][VP_W-1:0]    vp_vec;
  logic [NUM_EDGES-1:0][COORD_W-1:0] sc_vec;
  logic [NUM_EDGES-1:0][COORD_W-1:0] bnd_w;
  logic [NUM_EDGES-1:0][COORD_W-1:0] fin_w;
  logic [NUM_EDGES-1:0][COORD_W-1:0] fin_q;
  logic [COORD_W-1:0]                limit_w;
  logic [WORD_W-1:0]                 tl_w, br_w;
  logic                              empty_w;
  logic [1:0]                        mode_q;
  logic                              load_evt;

  assign vp_vec[IDX_MINX] = vp_minx_i;
  assign vp_vec[IDX_MINY] = vp_miny_i;
  assign vp_vec[IDX_MAXX] = vp_maxx_i;
  assign vp_vec[IDX_MAXY] = vp_maxy_i;
  assign sc_vec[IDX_MINX] = sc_minx_i;
  assign sc_vec[IDX_MINY] = sc_miny_i;
  assign sc_vec[IDX_MAXX] = sc_maxx_i;
  assign sc_vec[IDX_MAXY] = sc_maxy_i;

  assign load_evt = load_i;

  vsc_bound #(
    .COORD_W(COORD_W), .VP_W(VP_W), .LIM_OLD(LIM_OLD), .LIM_NEW(LIM_NEW)
  ) u_bound (
    .mode_i  (mode_i),
    .wspace_i(wspace_i),
    .vp_i    (vp_vec),
    .bnd_o   (bnd_w),
    .limit_o (limit_w)
  );

  vsc_intersect #(.COORD_W(COORD_W)) u_isect (
    .sc_en_i(sc_en_i),
    .bnd_i  (bnd_w),
    .sc_i   (sc_vec),
    .fin_o  (fin_w)
  );

  vsc_encode #(.COORD_W(COORD_W), .WORD_W(WORD_W)) u_enc (
    .mode_i (mode_i),
    .fin_i  (fin_w),
    .empty_o(empty_w),
    .tl_o   (tl_w),
    .br_o   (br_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fin_q  <= '0;
      mode_q <= MODE_LEGACY;
      tl_o   <= '0;
      br_o   <= '0;
    end else if (load_evt) begin
      fin_q  <= fin_w;
      mode_q <= mode_i;
      tl_o   <= tl_w;
      br_o   <= br_w;
    end
  end

  vsc_pixel_test #(.COORD_W(COORD_W)) u_pix (
    .clk     (clk),
    .rst_n   (rst_n),
    .rect_i  (fin_q),
    .px_x_i  (px_x_i),
    .px_y_i  (px_y_i),
    .inside_o(inside_o)
  );

endmodule

// File: rtl/vsc_checker.sv
module vsc_checker
  import vsc_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int LIM_OLD = 16384,
  parameter int LIM_NEW = 32768,
  parameter int WORD_W  = 2 * COORD_W + 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              load_i,
  input logic [1:0]                        mode_i,
  input logic [WORD_W-1:0]                 tl_o,
  input logic [WORD_W-1:0]                 br_o,
  input logic                              inside_o,
  input logic [NUM_EDGES-1:0][COORD_W-1:0] fin_q,
  input logic [1:0]                        mode_q
);

  logic [COORD_W-1:0] lim_q;
  logic               stored_empty;
  assign lim_q        = (mode_q == MODE_NEW) ? COORD_W'(LIM_NEW) : COORD_W'(LIM_OLD);
  assign stored_empty = (fin_q[IDX_MAXX] == '0) || (fin_q[IDX_MAXY] == '0);

  AST_MAX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q[IDX_MAXX] <= lim_q) && (fin_q[IDX_MAXY] <= lim_q)); // R1

  AST_LEGACY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_i) && ($past(mode_i) != MODE_NEW)) |-> tl_o[WORD_W-1]); // R4

  AST_NEW_INCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_NEW) && !stored_empty) |->
      (({1'b0, br_o[COORD_W-1:0]} + 1'b1) == {1'b0, fin_q[IDX_MAXX]}) && !tl_o[WORD_W-1]); // R5

  AST_NEW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_NEW) && stored_empty) |->
      (tl_o == {1'b0, COORD_W'(1), COORD_W'(1)}) && (br_o == '0)); // R6

  AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_i) |-> ($stable(tl_o) && $stable(br_o))); // R8

  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stored_empty) |-> !inside_o); // R9

endmodule

bind vp_scissor_composer vsc_checker #(
  .COORD_W(COORD_W), .LIM_OLD(LIM_OLD), .LIM_NEW(LIM_NEW)
) u_vsc_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_i  (load_i),
  .mode_i  (mode_i),
  .tl_o    (tl_o),
  .br_o    (br_o),
  .inside_o(inside_o),
  .fin_q   (fin_q),
  .mode_q  (mode_q)
);

// File: tb/vp_scissor_composer_bench.sv
module vp_scissor_composer_bench;

  localparam int CW = 16;
  localparam int VW = CW + 2;
  localparam int WW = 2 * CW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic [1:0] mode_i = 2'd1;
  logic wspace_i = 1'b0;
  logic signed [VW-1:0] vp_minx_i = '0, vp_miny_i = '0, vp_maxx_i = '0, vp_maxy_i = '0;
  logic sc_en_i = 1'b0;
  logic [CW-1:0] sc_minx_i = '0, sc_miny_i = '0, sc_maxx_i = '0, sc_maxy_i = '0;
  logic [CW-1:0] px_x_i = '0, px_y_i = '0;
  logic [WW-1:0] tl_o, br_o;
  logic inside_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  vp_scissor_composer u_vp_scissor_composer (
    .clk, .rst_n, .load_i, .mode_i, .wspace_i,
    .vp_minx_i, .vp_miny_i, .vp_maxx_i, .vp_maxy_i,
    .sc_en_i, .sc_minx_i, .sc_miny_i, .sc_maxx_i, .sc_maxy_i,
    .px_x_i, .px_y_i, .tl_o, .br_o, .inside_o
  );

  function automatic logic [WW-1:0] w(input logic f, input int y, input int x);
    return {f, CW'(y), CW'(x)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_rect(input int m, input bit ws, input int vx0, input int vy0,
                           input int vx1, input int vy1, input bit en,
                           input int sx0, input int sy0, input int sx1, input int sy1);
    @(negedge clk);
    mode_i = 2'(m); wspace_i = ws;
    vp_minx_i = VW'(vx0); vp_miny_i = VW'(vy0); vp_maxx_i = VW'(vx1); vp_maxy_i = VW'(vy1);
    sc_en_i = en;
    sc_minx_i = CW'(sx0); sc_miny_i = CW'(sy0); sc_maxx_i = CW'(sx1); sc_maxy_i = CW'(sy1);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic check_words(input string req, input logic [WW-1:0] etl, input logic [WW-1:0] ebr);
    check({req, " tl"}, 64'(tl_o), 64'(etl));
    check({req, " br"}, 64'(br_o), 64'(ebr));
  endtask

  task automatic probe(input string req, input int x, input int y, input bit exp);
    @(negedge clk);
    px_x_i = CW'(x); px_y_i = CW'(y);
    @(negedge clk);
    check(req, 64'(inside_o), 64'(exp));
  endtask

  task automatic t_reset;
    check_words("R10 reset", '0, '0);
    check("R10 inside", 64'(inside_o), 64'(0));
    probe("R10 empty after reset", 0, 0, 1'b0);
  endtask

  task automatic t_legacy_plain;
    load_rect(1, 0, 10, 20, 100, 200, 0, 0, 0, 0, 0);
    check_words("R4 legacy plain", w(1, 20, 10), w(0, 200, 100));
  endtask

  task automatic t_clamp;
    load_rect(1, 0, -50, -5, 20000, 40000, 0, 0, 0, 0, 0);
    check_words("R1 clamp legacy", w(1, 0, 0), w(0, 16384, 16384));
    load_rect(2, 0, -50, -5, 20000, 40000, 0, 0, 0, 0, 0);
    check_words("R1 R5 clamp new", w(0, 0, 0), w(0, 32767, 19999));
  endtask

  task automatic t_bypass;
    load_rect(2, 1, 500, 500, 600, 600, 0, 0, 0, 0, 0);
    check_words("R2 bypass new", w(0, 0, 0), w(0, 32767, 32767));
    load_rect(0, 1, -9, 7, 3, 4, 0, 0, 0, 0, 0);
    check_words("R2 bypass oldest", w(1, 0, 0), w(0, 16384, 16384));
  endtask

  task automatic t_scissor;
    load_rect(1, 0, 0, 0, 1000, 1000, 0, 100, 50, 2000, 500);
    check_words("R3 scissor disabled", w(1, 0, 0), w(0, 1000, 1000));
    load_rect(3, 0, 0, 0, 1000, 1000, 1, 100, 50, 2000, 500);
    check_words("R3 R4 scissor mode3", w(1, 50, 100), w(0, 500, 1000));
    load_rect(1, 0, 0, 0, 1000, 1000, 1, 100, 50, 2000, 500);
    check_words("R3 scissor enabled", w(1, 50, 100), w(0, 500, 1000));
  endtask

  task automatic t_hold;
    @(negedge clk);
    mode_i = 2'd2; wspace_i = 1'b1; sc_en_i = 1'b0;
    vp_minx_i = VW'(7); vp_maxx_i = VW'(9);
    repeat (3) @(negedge clk);
    check_words("R8 hold without load", w(1, 50, 100), w(0, 500, 1000));
  endtask

  task automatic t_pixels;
    probe("R9 top-left corner in", 100, 50, 1'b1);
    probe("R9 last pixel in", 999, 499, 1'b1);
    probe("R9 right edge out", 1000, 50, 1'b0);
    probe("R9 left of min out", 99, 60, 1'b0);
    probe("R9 bottom edge out", 500, 500, 1'b0);
    load_rect(2, 0, 0, 0, 64, 32, 0, 0, 0, 0, 0);
    check_words("R5 new inclusive", w(0, 0, 0), w(0, 31, 63));
    probe("R9 new mode last in", 63, 31, 1'b1);
    probe("R9 new mode x out", 64, 0, 1'b0);
    probe("R9 new mode y out", 0, 32, 1'b0);
  endtask

  task automatic t_empty;
    load_rect(2, 0, 10, 10, -20, 300, 0, 0, 0, 0, 0);
    check_words("R6 new empty by clamp", w(0, 1, 1), '0);
    probe("R9 empty rect no hit", 5, 5, 1'b0);
    load_rect(2, 0, 0, 0, 100, 100, 1, 0, 0, 50, 0);
    check_words("R6 new empty by scissor", w(0, 1, 1), '0);
    load_rect(0, 0, 10, 10, -20, 300, 0, 0, 0, 0, 0);
    check_words("R7 oldest empty", w(1, 1, 1), w(0, 1, 1));
    load_rect(1, 0, 10, 10, -20, 300, 0, 0, 0, 0, 0);
    check_words("R7 legacy empty plain", w(1, 10, 10), w(0, 300, 0));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legacy_plain();
    t_clamp();
    t_bypass();
    t_scissor();
    t_hold();
    load_rect(1, 0, 0, 0, 1000, 1000, 1, 100, 50, 2000, 500);
    t_pixels();
    t_empty();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule